// File: doc/BRIEF.md
# Dual-Edge Nibble Upload Serializer

This block moves 16-bit words from a local buffer to a host over a 4-bit path. The host supplies a slow, possibly noisy strobe. Every accepted strobe transition, rising or falling, puts the next nibble on the output pins, so one strobe period carries two nibbles and one word takes two periods. The strobe is brought into the system clock domain, filtered against bounce and turned into edge pulses. A toggle bit that flips on each falling edge is combined with the filtered level to choose which quarter of the current word is shown.

The block holds the buffer FIFO, which the memory arbiter fills. It asks for refills with a need_data request that has hysteresis: the request is raised when the buffer runs low and is held until the buffer is nearly full. Headroom above the upper mark absorbs the writes the arbiter still delivers after the request drops. A status output shows whether the host is actively clocking data, so that software can tell an idle host apart from a starved buffer. A sticky flag records any word boundary that found the buffer empty.

Top module: `nib_uplink`

## Requirements
- R1: While rst_ni is low, nib_o, need_data_o, uploading_o and underflow_o are all 0.
- R2: host_strb_i passes through a two-stage synchronizer. The filtered level takes a new value only after the synchronized strobe has differed from it for DB_CYCLES consecutive clocks. A shorter pulse moves no nibble.
- R3: nib_o shows the nibble at position {toggle, level}. Position 0 is bits 15:12, position 1 is bits 11:8, position 2 is bits 7:4 and position 3 is bits 3:0, so the most significant nibble goes first. nib_o changes only on an accepted strobe edge or on a word load.
- R4: Each accepted edge advances the position. A rising edge sets the level bit. A falling edge clears it and inverts the toggle bit.
- R5: The first word written after reset is loaded as soon as the FIFO holds it, with no strobe edge needed. After that, a new word is loaded on the falling edge that ends position 3.
- R6: One clock after the FIFO count is at or below LOW_MARK, need_data_o is 1. One clock after the count is at or above HIGH_MARK, need_data_o is 0. Between the marks it keeps its value.
- R7: The FIFO holds DEPTH words. A write that arrives while the FIFO is full is dropped, and no almost-full flag gates writes.
- R8: If a word boundary is reached while the FIFO is empty, underflow_o goes to 1 and stays at 1 until reset, and the last word stays on the output.
- R9: uploading_o goes to 1 on the clock after an accepted edge. It returns to 0 after IDLE_CYCLES clocks with no accepted edge.
- R10: Words leave the block in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_strb_i | input | 1 | Host strobe, asynchronous to clk_i |
| wr_en_i | input | 1 | Write of one word from the memory arbiter |
| wr_data_i | input | 16 | Word to store |
| need_data_o | output | 1 | Refill request with hysteresis |
| nib_o | output | 4 | Nibble presented to the host |
| uploading_o | output | 1 | Host has clocked the strobe recently |
| underflow_o | output | 1 | Sticky: a word boundary found the FIFO empty |

## Verification
The hardest situation to reach is a word boundary that finds the FIFO empty. It needs the refill source to stall while the host keeps clocking, and then a check that the held word is presented again from its first nibble. The bench gets there by switching off its lagging arbiter model and running strobe periods until the buffer drains. The arbiter model answers need_data_o two clocks late, so the buffer overshoots the upper mark and writes into a full FIFO are dropped. A strobe pulse shorter than the filter window is also driven, to show that glitch rejection leaves the nibble unchanged.

// File: rtl/nib_uplink_pkg.sv
package nib_uplink_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned NIB_CNT = WORD_W / NIB_W;
  localparam int unsigned POS_W   = $clog2(NIB_CNT);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [POS_W-1:0]  pos_t;
endpackage

// File: rtl/strb_cond.sv
module strb_cond #(
  parameter int unsigned DB_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_i,
  output logic sync_o,
  output logic lvl_o,
  output logic edge_o
);
  localparam int unsigned DB_W = $clog2(DB_CYCLES) + 1;

  logic            s1_q, s2_q;
  logic            lvl_q, lvl_d_q;
  logic [DB_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= strb_i;
      s2_q <= s1_q;
    end
  end

  // level accepted after DB_CYCLES consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (s2_q == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == DB_W'(DB_CYCLES - 1)) begin
      lvl_q <= s2_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else         lvl_d_q <= lvl_q;
  end

  assign sync_o = s2_q;
  assign lvl_o  = lvl_q;
  assign edge_o = lvl_q ^ lvl_d_q;
endmodule

// File: rtl/word_fifo.sv
module word_fifo
  import nib_uplink_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  word_t                      data_i,
  input  logic                       pop_i,
  output word_t                      head_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  word_t            mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/refill_ctl.sv
module refill_ctl #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned LOW_MARK  = 4,
  parameter int unsigned HIGH_MARK = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(DEPTH+1)-1:0] cnt_i,
  output logic                       need_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic need_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          need_q <= 1'b0;
    else if (cnt_i <= CNT_W'(LOW_MARK))   need_q <= 1'b1;
    else if (cnt_i >= CNT_W'(HIGH_MARK))  need_q <= 1'b0;
  end

  assign need_o = need_q;
endmodule

// File: rtl/nib_ser.sv
module nib_ser
  import nib_uplink_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  logic  edge_i,
  input  word_t head_i,
  input  logic  empty_i,
  output logic  pop_o,
  output logic  primed_o,
  output nib_t  nib_o,
  output logic  underflow_o
);
  logic  tog_q, ph_q, primed_q, undf_q;
  word_t cur_q;
  logic  fall, wrap, load;
  pos_t  pos;

  assign fall = edge_i && !lvl_i;
  assign wrap = fall && tog_q;
  assign load = !empty_i && (!primed_q || wrap);
  assign pos  = {tog_q, ph_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      ph_q  <= 1'b0;
    end else if (edge_i) begin
      ph_q <= lvl_i;
      if (fall) tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      primed_q <= 1'b0;
      undf_q   <= 1'b0;
    end else begin
      if (load) begin
        cur_q    <= head_i;
        primed_q <= 1'b1;
      end
      // empty at a boundary: keep last word
      if (wrap && empty_i) undf_q <= 1'b1;
    end
  end

  always_comb begin
    nib_o = '0;
    for (int i = 0; i < NIB_CNT; i++) begin
      if (pos == POS_W'(i)) nib_o = cur_q[WORD_W-1-i*NIB_W -: NIB_W];
    end
  end

  assign pop_o       = load;
  assign primed_o    = primed_q;
  assign underflow_o = undf_q;
endmodule

// File: rtl/act_mon.sv
module act_mon #(
  parameter int unsigned IDLE_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic active_o
);
  localparam int unsigned IDLE_W = $clog2(IDLE_CYCLES) + 1;

  logic [IDLE_W-1:0] idle_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      idle_q <= '0;
    end else if (edge_i) begin
      act_q  <= 1'b1;
      idle_q <= '0;
    end else if (act_q) begin
      if (idle_q == IDLE_W'(IDLE_CYCLES - 1)) begin
        act_q  <= 1'b0;
        idle_q <= '0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/nib_uplink.sv
module nib_uplink
  import nib_uplink_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned LOW_MARK    = 4,
  parameter int unsigned HIGH_MARK   = 10,
  parameter int unsigned DB_CYCLES   = 4,
  parameter int unsigned IDLE_CYCLES = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_strb_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic        need_data_o,
  output logic [3:0]  nib_o,
  output logic        uploading_o,
  output logic        underflow_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             strb_sync, strb_lvl, strb_edge;
  logic             fifo_pop, fifo_empty, ser_primed;
  word_t            fifo_head;
  logic [CNT_W-1:0] fifo_cnt;

  strb_cond #(.DB_CYCLES(DB_CYCLES)) i_strb_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_i (host_strb_i),
    .sync_o (strb_sync),
    .lvl_o  (strb_lvl),
    .edge_o (strb_edge)
  );

  word_fifo #(.DEPTH(DEPTH)) i_word_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_en_i),
    .data_i  (wr_data_i),
    .pop_i   (fifo_pop),
    .head_o  (fifo_head),
    .empty_o (fifo_empty),
    .cnt_o   (fifo_cnt)
  );

  refill_ctl #(
    .DEPTH     (DEPTH),
    .LOW_MARK  (LOW_MARK),
    .HIGH_MARK (HIGH_MARK)
  ) i_refill_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (fifo_cnt),
    .need_o (need_data_o)
  );

  nib_ser i_nib_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (strb_lvl),
    .edge_i      (strb_edge),
    .head_i      (fifo_head),
    .empty_i     (fifo_empty),
    .pop_o       (fifo_pop),
    .primed_o    (ser_primed),
    .nib_o       (nib_o),
    .underflow_o (underflow_o)
  );

  act_mon #(.IDLE_CYCLES(IDLE_CYCLES)) i_act_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (strb_edge),
    .active_o (uploading_o)
  );
endmodule

// File: rtl/nib_uplink_chk.sv
module nib_uplink_chk #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned LOW_MARK  = 4,
  parameter int unsigned HIGH_MARK = 10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sync_i,
  input logic                       lvl_i,
  input logic                       edge_i,
  input logic                       primed_i,
  input logic [3:0]                 nib_i,
  input logic [$clog2(DEPTH+1)-1:0] cnt_i,
  input logic                       need_i,
  input logic                       underflow_i,
  input logic                       uploading_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  a_r2_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i == lvl_i) |=> $stable(lvl_i));

  a_r3_nib_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_i && !edge_i) |=> $stable(nib_i));

  a_r6_need_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i <= CNT_W'(LOW_MARK)) |=> need_i);

  a_r6_need_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i >= CNT_W'(HIGH_MARK)) |=> !need_i);

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_i |=> underflow_i);

  a_r9_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> uploading_i);
endmodule

bind nib_uplink nib_uplink_chk #(
  .DEPTH     (DEPTH),
  .LOW_MARK  (LOW_MARK),
  .HIGH_MARK (HIGH_MARK)
) i_nib_uplink_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (strb_sync),
  .lvl_i       (strb_lvl),
  .edge_i      (strb_edge),
  .primed_i    (ser_primed),
  .nib_i       (nib_o),
  .cnt_i       (fifo_cnt),
  .need_i      (need_data_o),
  .underflow_i (underflow_o),
  .uploading_i (uploading_o)
);

// File: tb/test_nib_uplink.sv
module test_nib_uplink;
  localparam int DEPTH = 8;
  localparam int LOW   = 2;
  localparam int HIGH  = 6;
  localparam int DB    = 3;
  localparam int IDLE  = 40;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_strb = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        need_data, uploading, underflow;
  logic [3:0]  nib;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  nib_uplink #(
    .DEPTH(DEPTH), .LOW_MARK(LOW), .HIGH_MARK(HIGH),
    .DB_CYCLES(DB), .IDLE_CYCLES(IDLE)
  ) i_nib_uplink (
    .clk_i(clk), .rst_ni(rst_ni), .host_strb_i(host_strb),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .need_data_o(need_data),
    .nib_o(nib), .uploading_o(uploading), .underflow_o(underflow)
  );

  // reference model state
  logic [15:0] q[$];
  bit   m_s1, m_s2, m_lvl, m_lvl_d, m_tog, m_ph, m_primed, m_undf, m_need, m_upl;
  int   m_cnt, m_idle;
  logic [15:0] m_cur;

  // stimulus controls
  bit          strb_v = 0;
  bit          arb_on = 0;
  bit          man_wen = 0;
  logic [15:0] man_dat = '0;
  logic [15:0] arb_ctr = 16'h2C4E;
  bit          need_d1 = 0, need_d2 = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_nib();
    int pos = {m_tog, m_ph};
    return (m_cur >> (12 - 4 * pos)) & 4'hF;
  endfunction

  task automatic model_step(input bit s, input bit we, input logic [15:0] wd);
    bit edge_p, fall, wrap, empty, load;
    int occ;
    edge_p = (m_lvl != m_lvl_d);
    fall   = edge_p && !m_lvl;
    wrap   = fall && m_tog;
    occ    = q.size();
    empty  = (occ == 0);
    load   = !empty && (!m_primed || wrap);
    // refill request from current occupancy
    if (occ <= LOW) m_need = 1;
    else if (occ >= HIGH) m_need = 0;
    // activity
    if (edge_p) begin m_upl = 1; m_idle = 0; end
    else if (m_upl) begin
      if (m_idle == IDLE - 1) begin m_upl = 0; m_idle = 0; end
      else m_idle++;
    end
    if (wrap && empty) m_undf = 1;
    if (load) begin m_cur = q.pop_front(); m_primed = 1; end
    if (we && occ < DEPTH) q.push_back(wd);
    if (edge_p) begin
      m_ph = m_lvl;
      if (fall) m_tog = !m_tog;
    end
    m_lvl_d = m_lvl;
    if (m_s2 == m_lvl) m_cnt = 0;
    else if (m_cnt == DB - 1) begin m_lvl = m_s2; m_cnt = 0; end
    else m_cnt++;
    m_s2 = m_s1;
    m_s1 = s;
  endtask

  // one clock: compare, drive, advance model, wait
  task automatic cyc();
    bit we;
    logic [15:0] wd;
    chk("R3/R7/R10 nibble", nib, m_nib());
    chk("R6 need_data", need_data, m_need);
    chk("R9 uploading", uploading, m_upl);
    chk("R8 underflow", underflow, m_undf);
    we = man_wen;
    wd = man_dat;
    if (arb_on && need_d2) begin
      we = 1;
      wd = arb_ctr;
      arb_ctr = arb_ctr + 16'h3B5D;
    end
    need_d2 = need_d1;
    need_d1 = need_data;
    host_strb = strb_v;
    wr_en = we;
    wr_data = wd;
    model_step(strb_v, we, wd);
    man_wen = 0;
    @(negedge clk);
    cycles++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic period(input int half);
    strb_v = 1; run(half);
    strb_v = 0; run(half);
  endtask

  task automatic put(input logic [15:0] d);
    man_wen = 1; man_dat = d; cyc();
  endtask

  initial begin
    q.delete();
    {m_s1, m_s2, m_lvl, m_lvl_d, m_tog, m_ph, m_primed, m_undf, m_need, m_upl} = '0;
    m_cnt = 0; m_idle = 0; m_cur = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 nib_o", nib, 0);
    chk("R1 need_data_o", need_data, 0);
    chk("R1 uploading_o", uploading, 0);
    chk("R1 underflow_o", underflow, 0);
    rst_ni = 1'b1;
    run(2);

    // R5: first word loaded without strobe
    put(16'h1234);
    put(16'h5678);
    run(6);
    chk("R5 prime nibble", nib, 4'h1);
    chk("R6 need at low count", need_data, 1);

    // R2: pulse shorter than filter window
    strb_v = 1; run(2);
    strb_v = 0; run(10);
    chk("R2 glitch ignored", nib, 4'h1);
    chk("R2 glitch no activity", uploading, 0);

    // R3/R4: walk one word by edges
    strb_v = 1; run(8);
    chk("R4 rising edge nibble", nib, 4'h2);
    strb_v = 0; run(8);
    chk("R4 falling edge nibble", nib, 4'h3);
    strb_v = 1; run(8);
    chk("R3 last nibble", nib, 4'h4);
    strb_v = 0; run(8);
    chk("R5 next word on wrap", nib, 4'h5);
    chk("R9 active while clocking", uploading, 1);

    // lagging arbiter refills, many words
    arb_on = 1;
    for (int p = 0; p < 30; p++) period(6);

    // R8: starve the buffer
    arb_on = 0;
    for (int p = 0; p < 14; p++) period(6);
    chk("R8 underflow set", underflow, 1);

    // R9: host stops
    run(IDLE + 12);
    chk("R9 idle drop", uploading, 0);

    // R7: overfill then drain
    for (int i = 0; i < DEPTH + 3; i++) put(16'hA000 + 16'(i * 16'h0111));
    run(3);
    chk("R6 need cleared when full", need_data, 0);
    for (int p = 0; p < 2 * DEPTH + 4; p++) period(7);
    chk("R8 underflow still sticky", underflow, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule